// File: doc/BRIEF.md
# Dual-Port Pin Controller with Pullup Select

This block drives the pads of two general-purpose I/O ports: a wide port A with eight pins and a narrow port B with four. Each pin has three control bits held in registers: a direction bit, an output-data bit and an input-disable bit. Together they put the pin in one of three conditions: actively driven, input with a weak pullup, or input left floating. When a pin is an input, its output-data bit selects the pullup rather than a drive level.

Software reaches the registers over a plain write-strobe bus. Each address is a 4-bit module number and a 5-bit register index. Only module 0 answers. Reads are combinational from the address. The pad side gets four per-pin control signals: drive enable, drive value, pullup enable and input-buffer enable. The pin levels come back through a two-flop synchronizer and can be read as registers.

Register indices within module 0:
- 10h is port A direction and 11h is port B direction.
- 08h is port A output data and 09h is port B output data.
- 0Dh is port A input disable and 0Eh is port B input disable.
- 00h is port A pin level and 01h is port B pin level. Both are read-only.

Data bit n always maps to pin n.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every direction, output-data and input-disable bit is 0. All six control registers read 0, drive and pullup enables are 0, and every input-buffer enable is 1.
- R2: A write to a direction or output-data index takes effect at the clock edge that samples the strobe, and reads back the written value. A direction bit of 1 asserts drive enable for that pin, and the drive value equals the pin's output-data bit.
- R3: Pullup enable for a pin is 1 exactly when its direction bit is 0 and its output-data bit is 1. Drive and pullup enables are never both 1 on the same pin.
- R4: An input-disable bit of 1 clears that pin's input-buffer enable, and its bit in the pin-level register reads 0. A bit of 0 keeps the buffer enabled.
- R5: The pin-level registers (00h, 01h) return each pin through two flops. A pin change seen at one edge is readable after the second edge. Writes to these indices are ignored.
- R6: Port B registers implement bits 3..0 only. Bits 7..4 read 0 and writes to them are ignored.
- R7: A write with a module number other than 0 changes no register. A read with such a module number returns 0.
- R8: A read of an unmapped index in module 0 returns 0. A write to it changes no register and no pad output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| mod_sel | input | 4 | Module number of the access |
| idx_sel | input | 5 | Register index of the access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| pin_in_a | input | 8 | Port A pad levels |
| pin_in_b | input | 4 | Port B pad levels |
| drv_en_a | output | 8 | Port A drive enables |
| drv_val_a | output | 8 | Port A drive levels |
| pull_en_a | output | 8 | Port A weak-pullup enables |
| ibuf_en_a | output | 8 | Port A input-buffer enables |
| drv_en_b | output | 4 | Port B drive enables |
| drv_val_b | output | 4 | Port B drive levels |
| pull_en_b | output | 4 | Port B weak-pullup enables |
| ibuf_en_b | output | 4 | Port B input-buffer enables |

## Verification
The bench builds the block with its default parameters: an 8-pin port A, a 4-pin port B, an 8-bit data word and module number 0. With these values, port B is narrower than the data word, so writes with all ones show that bits 7..4 are dropped. A pin-level change is sampled on each side of the second edge, which makes the synchronizer lag visible. Module 1 is also reachable for the foreign-module cases.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    typedef enum logic [2:0] {
        FLD_NONE,
        FLD_DIR,
        FLD_OUT,
        FLD_IDIS,
        FLD_PIN
    } field_e;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_port_pkg::*;
#(
    parameter int MOD_W      = 4,
    parameter int IDX_W      = 5,
    parameter int MOD_ID     = 0,
    parameter int IDX_PIN_A  = 'h00,
    parameter int IDX_PIN_B  = 'h01,
    parameter int IDX_OUT_A  = 'h08,
    parameter int IDX_OUT_B  = 'h09,
    parameter int IDX_IDIS_A = 'h0D,
    parameter int IDX_IDIS_B = 'h0E,
    parameter int IDX_DIR_A  = 'h10,
    parameter int IDX_DIR_B  = 'h11
) (
    input  logic [MOD_W-1:0] mod_sel,
    input  logic [IDX_W-1:0] idx_sel,
    output field_e           fld_a,
    output field_e           fld_b
);
    localparam logic [MOD_W-1:0] MOD_MATCH = MOD_W'(MOD_ID);

    always_comb begin
        fld_a = FLD_NONE;
        fld_b = FLD_NONE;
        if (mod_sel == MOD_MATCH) begin
            if      (idx_sel == IDX_W'(IDX_DIR_A))  fld_a = FLD_DIR;
            else if (idx_sel == IDX_W'(IDX_OUT_A))  fld_a = FLD_OUT;
            else if (idx_sel == IDX_W'(IDX_IDIS_A)) fld_a = FLD_IDIS;
            else if (idx_sel == IDX_W'(IDX_PIN_A))  fld_a = FLD_PIN;
            else if (idx_sel == IDX_W'(IDX_DIR_B))  fld_b = FLD_DIR;
            else if (idx_sel == IDX_W'(IDX_OUT_B))  fld_b = FLD_OUT;
            else if (idx_sel == IDX_W'(IDX_IDIS_B)) fld_b = FLD_IDIS;
            else if (idx_sel == IDX_W'(IDX_PIN_B))  fld_b = FLD_PIN;
        end
    end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk
            logic [1:0] warm_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)              warm_q <= '0;
                else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
            end
            assert_sync_lag_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (warm_q == 2'd2) |-> (q == $past(d, 2)));
        end
    endgenerate
endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
    import gpio_port_pkg::*;
#(
    parameter int PINS        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  field_e          fld,
    input  logic [PINS-1:0] wr_bits,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] drv_en,
    output logic [PINS-1:0] drv_val,
    output logic [PINS-1:0] pull_en,
    output logic [PINS-1:0] ibuf_en,
    output logic [PINS-1:0] rd_bits
);
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] out_q;
    logic [PINS-1:0] idis_q;
    logic [PINS-1:0] pin_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            out_q  <= '0;
            idis_q <= '0;
        end else if (wr_en) begin
            case (fld)
                FLD_DIR:  dir_q  <= wr_bits;
                FLD_OUT:  out_q  <= wr_bits;
                FLD_IDIS: idis_q <= wr_bits;
                default:  ;
            endcase
        end
    end

    generate
        for (genvar gi = 0; gi < PINS; gi++) begin : g_pin
            gpio_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .d    (pin_in[gi]),
                .q    (pin_sync[gi])
            );
        end
    endgenerate

    assign drv_en  = dir_q;
    assign drv_val = out_q;
    assign pull_en = ~dir_q & out_q;
    assign ibuf_en = ~idis_q;

    always_comb begin
        rd_bits = '0;
        case (fld)
            FLD_DIR:  rd_bits = dir_q;
            FLD_OUT:  rd_bits = out_q;
            FLD_IDIS: rd_bits = idis_q;
            FLD_PIN:  rd_bits = pin_sync & ibuf_en;
            default:  rd_bits = '0;
        endcase
    end

    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fld == FLD_DIR) |=> (drv_en == $past(wr_bits)));

    assert_pull_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pull_en & drv_en) == '0));

    assert_idis_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fld == FLD_IDIS) |=> (ibuf_en == ~$past(wr_bits)));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int MOD_W       = 4,
    parameter int IDX_W       = 5,
    parameter int DATA_W      = 8,
    parameter int PINS_A      = 8,
    parameter int PINS_B      = 4,
    parameter int MOD_ID      = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MOD_W-1:0]  mod_sel,
    input  logic [IDX_W-1:0]  idx_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [PINS_A-1:0] pin_in_a,
    input  logic [PINS_B-1:0] pin_in_b,
    output logic [PINS_A-1:0] drv_en_a,
    output logic [PINS_A-1:0] drv_val_a,
    output logic [PINS_A-1:0] pull_en_a,
    output logic [PINS_A-1:0] ibuf_en_a,
    output logic [PINS_B-1:0] drv_en_b,
    output logic [PINS_B-1:0] drv_val_b,
    output logic [PINS_B-1:0] pull_en_b,
    output logic [PINS_B-1:0] ibuf_en_b
);
    field_e            fld_a;
    field_e            fld_b;
    logic [PINS_A-1:0] rd_a;
    logic [PINS_B-1:0] rd_b;

    gpio_addr_decode #(
        .MOD_W (MOD_W),
        .IDX_W (IDX_W),
        .MOD_ID(MOD_ID)
    ) u_dec (
        .mod_sel(mod_sel),
        .idx_sel(idx_sel),
        .fld_a  (fld_a),
        .fld_b  (fld_b)
    );

    gpio_pin_bank #(.PINS(PINS_A), .SYNC_STAGES(SYNC_STAGES)) u_bank_a (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .fld    (fld_a),
        .wr_bits(wdata[PINS_A-1:0]),
        .pin_in (pin_in_a),
        .drv_en (drv_en_a),
        .drv_val(drv_val_a),
        .pull_en(pull_en_a),
        .ibuf_en(ibuf_en_a),
        .rd_bits(rd_a)
    );

    gpio_pin_bank #(.PINS(PINS_B), .SYNC_STAGES(SYNC_STAGES)) u_bank_b (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .fld    (fld_b),
        .wr_bits(wdata[PINS_B-1:0]),
        .pin_in (pin_in_b),
        .drv_en (drv_en_b),
        .drv_val(drv_val_b),
        .pull_en(pull_en_b),
        .ibuf_en(ibuf_en_b),
        .rd_bits(rd_b)
    );

    assign rdata = DATA_W'(rd_a) | DATA_W'(rd_b);

    assert_foreign_mod_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mod_sel != MOD_W'(MOD_ID)) |=>
            ($stable(drv_en_a) && $stable(drv_val_a) && $stable(ibuf_en_a) &&
             $stable(drv_en_b) && $stable(drv_val_b) && $stable(ibuf_en_b)));

    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_a == FLD_NONE && fld_b == FLD_NONE) |-> (rdata == '0));
endmodule

// File: tb/gpio_port_ctrl_test.sv
module gpio_port_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] mod_sel = '0;
    logic [4:0] idx_sel = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pin_in_a = '0;
    logic [3:0] pin_in_b = '0;
    logic [7:0] drv_en_a, drv_val_a, pull_en_a, ibuf_en_a;
    logic [3:0] drv_en_b, drv_val_b, pull_en_b, ibuf_en_b;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_port_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .mod_sel(mod_sel),
        .idx_sel(idx_sel), .wdata(wdata), .rdata(rdata),
        .pin_in_a(pin_in_a), .pin_in_b(pin_in_b),
        .drv_en_a(drv_en_a), .drv_val_a(drv_val_a),
        .pull_en_a(pull_en_a), .ibuf_en_a(ibuf_en_a),
        .drv_en_b(drv_en_b), .drv_val_b(drv_val_b),
        .pull_en_b(pull_en_b), .ibuf_en_b(ibuf_en_b)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] m, input logic [4:0] i, input logic [7:0] d);
        @(negedge clk);
        mod_sel = m; idx_sel = i; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] m, input logic [4:0] i,
                          input logic [7:0] exp, input string what);
        mod_sel = m; idx_sel = i;
        #1;
        check(rdata, exp, what);
    endtask

    task automatic t_reset;
        rd_chk(0, 5'h10, 8'h00, "R1 dir A");
        rd_chk(0, 5'h11, 8'h00, "R1 dir B");
        rd_chk(0, 5'h08, 8'h00, "R1 out A");
        rd_chk(0, 5'h09, 8'h00, "R1 out B");
        rd_chk(0, 5'h0D, 8'h00, "R1 idis A");
        rd_chk(0, 5'h0E, 8'h00, "R1 idis B");
        check(drv_en_a, 8'h00, "R1 drv_en_a");
        check(pull_en_a, 8'h00, "R1 pull_en_a");
        check(ibuf_en_a, 8'hFF, "R1 ibuf_en_a");
        check({4'h0, ibuf_en_b}, 8'h0F, "R1 ibuf_en_b");
    endtask

    task automatic t_unmapped;
        wr(0, 5'h05, 8'hFF);
        rd_chk(0, 5'h05, 8'h00, "R8 unmapped 05h");
        rd_chk(0, 5'h1F, 8'h00, "R8 unmapped 1Fh");
        check(drv_en_a, 8'h00, "R8 drv_en_a after stray write");
        check(drv_val_a, 8'h00, "R8 drv_val_a after stray write");
        check(ibuf_en_a, 8'hFF, "R8 ibuf_en_a after stray write");
        rd_chk(0, 5'h10, 8'h00, "R8 dir A after stray write");
    endtask

    task automatic t_drive;
        wr(0, 5'h10, 8'hA5);
        wr(0, 5'h08, 8'h0F);
        rd_chk(0, 5'h10, 8'hA5, "R2 dir A readback");
        rd_chk(0, 5'h08, 8'h0F, "R2 out A readback");
        check(drv_en_a, 8'hA5, "R2 drv_en_a");
        check(drv_val_a, 8'h0F, "R2 drv_val_a");
        check(pull_en_a, 8'h0A, "R3 pull_en_a mixed");
    endtask

    task automatic t_foreign_mod;
        wr(4'd1, 5'h10, 8'h00);
        check(drv_en_a, 8'hA5, "R7 drv_en_a after module 1 write");
        rd_chk(4'd1, 5'h10, 8'h00, "R7 module 1 read");
        rd_chk(0, 5'h10, 8'hA5, "R7 dir A kept");
    endtask

    task automatic t_pull;
        wr(0, 5'h10, 8'h00);
        wr(0, 5'h08, 8'hF0);
        check(pull_en_a, 8'hF0, "R3 pull_en_a all inputs");
        check(drv_en_a, 8'h00, "R3 drv_en_a all inputs");
    endtask

    task automatic t_port_b;
        wr(0, 5'h11, 8'hFF);
        rd_chk(0, 5'h11, 8'h0F, "R6 dir B upper bits");
        check({4'h0, drv_en_b}, 8'h0F, "R6 drv_en_b");
        wr(0, 5'h09, 8'hA3);
        rd_chk(0, 5'h09, 8'h03, "R6 out B upper bits");
        check({4'h0, drv_val_b}, 8'h03, "R2 drv_val_b");
        check({4'h0, pull_en_b}, 8'h00, "R3 pull_en_b driven");
        wr(0, 5'h11, 8'h00);
        check({4'h0, pull_en_b}, 8'h03, "R3 pull_en_b inputs");
    endtask

    task automatic t_sync;
        @(negedge clk);
        pin_in_a = 8'h3C;
        pin_in_b = 4'hF;
        @(negedge clk);
        rd_chk(0, 5'h00, 8'h00, "R5 pin A after one edge");
        @(negedge clk);
        rd_chk(0, 5'h00, 8'h3C, "R5 pin A after two edges");
        rd_chk(0, 5'h01, 8'h0F, "R5 pin B after two edges");
        wr(0, 5'h00, 8'hFF);
        rd_chk(0, 5'h00, 8'h3C, "R5 pin A write ignored");
    endtask

    task automatic t_idis;
        wr(0, 5'h0D, 8'h0C);
        rd_chk(0, 5'h00, 8'h30, "R4 pin A masked");
        check(ibuf_en_a, 8'hF3, "R4 ibuf_en_a");
        wr(0, 5'h0E, 8'h05);
        rd_chk(0, 5'h01, 8'h0A, "R4 pin B masked");
        check({4'h0, ibuf_en_b}, 8'h0A, "R4 ibuf_en_b");
        rd_chk(0, 5'h0E, 8'h05, "R4 idis B readback");
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unmapped();
        t_drive();
        t_foreign_mod();
        t_pull();
        t_port_b();
        t_sync();
        t_idis();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule